// File: doc/BRIEF.md
# Parallel Port FIFO Control Register

This block is the CPU-visible control register that sits in front of a parallel-port FIFO controller. A single 8-bit register is written and read by the host. Its bits start a DMA request toward an external DMA engine, fire single-cycle reset strobes at the FIFO and at the attached port logic, and choose the width of CPU accesses to the FIFO. A further field, together with one bit taken from a neighbouring interrupt-enable register, selects the port's operating mode.

A two-bit threshold field sets the FIFO fill level at which a data-available interrupt is raised. The interrupt is only raised while data flows from the device toward the host. The FIFO itself, the port bus sequencers and the DMA engine live elsewhere. The current fill count and the transfer direction arrive as inputs.

Top module: `ppfc_reg`

## Requirements
- R1: After reset, `rdData` reads 0x00, `dmaReq`, `fifoRstPulse`, `devRstPulse` and `wideAccess` are 0, and `opMode` is 0 (standard) while `ierBit1` is 0.
- R2: A write with `wrData[0]`=1 sets the DMA enable bit, and a write with `wrData[0]`=0 clears it. The bit reads back on `rdData[0]` in the cycle after the write edge.
- R3: `dmaReq` rises in the cycle after a write edge that takes the DMA enable bit from 0 to 1. A write of 1 while the bit is already 1 raises no new request.
- R4: While `dmaReq` is 1, an edge with `dmaAck`=1 drops it in the next cycle, unless that same edge also starts a new 0-to-1 request, in which case the set wins.
- R5: An edge with `dmaTc`=1 clears the DMA enable bit. If it coincides with a write that sets the bit, `dmaTc` wins: the bit ends at 0 and no request is raised.
- R6: A write with `wrData[1]`=1 makes `fifoRstPulse` high for exactly the one cycle after the write edge. Bit 1 always reads back as 0.
- R7: A write with `wrData[2]`=1 makes `devRstPulse` high for exactly the one cycle after the write edge. Bit 2 always reads back as 0.
- R8: `wideAccess` takes `wrData[3]` on each write (0 = byte accesses, 1 = four-byte accesses) and holds it between writes.
- R9: `opMode` decodes {`ierBit1`, bits 5:4} combinationally. When `ierBit1`=1, it is 4 (test) if bit 4 is 0 and 5 (peripheral emulation) if bit 4 is 1. When `ierBit1`=0, it equals bits 5:4, where 0 = standard, 1 = bidirectional, 2 = fast standard and 3 = ECP.
- R10: `dataAvailIrq` is 1 exactly when `reverseDir`=1 and `fifoLevel` is at least the level selected by bits 7:6 (codes 0,1,2,3 select 1,4,8,14). It is 0 whenever `reverseDir`=0.
- R11: `rdData` returns {threshold[1:0], mode[1:0], width, 0, 0, DMA enable} from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value |
| ierBit1 | input | 1 | Mode-select bit borrowed from the interrupt-enable register |
| dmaAck | input | 1 | Acknowledge from DMA engine |
| dmaTc | input | 1 | Terminal count from DMA engine |
| dmaReq | output | 1 | Request to DMA engine |
| fifoRstPulse | output | 1 | One-cycle FIFO reset |
| devRstPulse | output | 1 | One-cycle device reset |
| wideAccess | output | 1 | 0 byte, 1 four-byte CPU FIFO access |
| opMode | output | 3 | Decoded operating mode |
| fifoLevel | input | 5 | Current FIFO fill count |
| reverseDir | input | 1 | 1 while data flows device to host |
| dataAvailIrq | output | 1 | Data-available interrupt |

## Verification
The terminal-count clear and a CPU write that sets DMA enable can land on the same edge, and so can an acknowledge and a fresh request set. Directed steps put `dmaTc` beside a write of 1, and `dmaAck` beside a re-arming write. A long random run with frequent `dmaTc`, `dmaAck` and writes then produces many more such collisions. Each cycle's enable, request and pulse outputs are compared against a bench model that applies the priorities stated in R4 and R5.

// File: rtl/ppfc_pkg.sv
package ppfc_pkg;

  typedef enum logic [2:0] {
    MODE_STD   = 3'd0,
    MODE_BIDIR = 3'd1,
    MODE_FAST  = 3'd2,
    MODE_ECP   = 3'd3,
    MODE_TEST  = 3'd4,
    MODE_EMUL  = 3'd5
  } ppfc_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;   // load width, mode and threshold fields
    logic enSet;   // DMA enable goes to 1
    logic enClr;   // DMA enable goes to 0
    logic reqSet;  // enable edge 0 -> 1 accepted
  } ppfc_strobe_t;

  localparam int NUM_PULSE = 2;
  localparam int NUM_THR   = 4;

  function automatic ppfc_mode_e decodeMode(input logic hi, input logic [1:0] sel);
    ppfc_mode_e m;
    if (hi) m = sel[0] ? MODE_EMUL : MODE_TEST;
    else begin
      case (sel)
        2'd0:    m = MODE_STD;
        2'd1:    m = MODE_BIDIR;
        2'd2:    m = MODE_FAST;
        default: m = MODE_ECP;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/ppfc_ctrl.sv
module ppfc_ctrl
  import ppfc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           wrLow,
  input  logic                 dmaTc,
  input  logic                 dmaAck,
  input  logic                 dmaEnNow,
  output ppfc_strobe_t         strb,
  output logic                 dmaReq,
  output logic [NUM_PULSE-1:0] rstPulse
);

  always_comb begin
    strb.cfgWr  = wrEn;
    strb.enSet  = wrEn && wrLow[0] && !dmaTc;
    strb.enClr  = dmaTc || (wrEn && !wrLow[0]);
    strb.reqSet = wrEn && wrLow[0] && !dmaTc && !dmaEnNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dmaReq <= 1'b0;
    else if (strb.reqSet) dmaReq <= 1'b1;
    else if (dmaAck)      dmaReq <= 1'b0;
  end

  // self-clearing reset strobes, one per write bit 1..NUM_PULSE
  for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (!rstN) rstPulse[p] <= 1'b0;
      else       rstPulse[p] <= wrEn && wrLow[p+1];
    end
  end

endmodule

// File: rtl/ppfc_datapath.sv
module ppfc_datapath
  import ppfc_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int TH_L0 = 1,
  parameter int TH_L1 = 4,
  parameter int TH_L2 = 8,
  parameter int TH_L3 = 14
) (
  input  logic          clk,
  input  logic          rstN,
  input  ppfc_strobe_t  strb,
  input  logic [7:3]    wrHigh,
  input  logic          ierBit1,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic          reverseDir,
  output logic          dmaEn,
  output logic          wideAccess,
  output logic [2:0]    opMode,
  output logic          dataAvailIrq,
  output logic [7:0]    rdData
);

  localparam int TH_TAB [NUM_THR] = '{TH_L0, TH_L1, TH_L2, TH_L3};

  logic [1:0] modeSel;
  logic [1:0] thrSel;
  logic [NUM_THR-1:0] thrHit;

  always_ff @(posedge clk) begin
    if (!rstN)           dmaEn <= 1'b0;
    else if (strb.enClr) dmaEn <= 1'b0;
    else if (strb.enSet) dmaEn <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideAccess <= 1'b0;
      modeSel    <= 2'd0;
      thrSel     <= 2'd0;
    end else if (strb.cfgWr) begin
      wideAccess <= wrHigh[3];
      modeSel    <= wrHigh[5:4];
      thrSel     <= wrHigh[7:6];
    end
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign thrHit[t] = (fifoLevel >= LVL_W'(TH_TAB[t]));
  end

  always_comb begin
    opMode       = decodeMode(ierBit1, modeSel);
    dataAvailIrq = reverseDir && thrHit[thrSel];
    rdData       = {thrSel, modeSel, wideAccess, 2'b00, dmaEn};
  end

endmodule

// File: rtl/ppfc_reg.sv
module ppfc_reg
  import ppfc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int TH_L0      = 1,
  parameter int TH_L1      = 4,
  parameter int TH_L2      = 8,
  parameter int TH_L3      = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             ierBit1,
  input  logic             dmaAck,
  input  logic             dmaTc,
  output logic             dmaReq,
  output logic             fifoRstPulse,
  output logic             devRstPulse,
  output logic             wideAccess,
  output logic [2:0]       opMode,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             reverseDir,
  output logic             dataAvailIrq
);

  ppfc_strobe_t         strb;
  logic                 dmaEn;
  logic [NUM_PULSE-1:0] rstPulse;

  ppfc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrLow    (wrData[2:0]),
    .dmaTc    (dmaTc),
    .dmaAck   (dmaAck),
    .dmaEnNow (dmaEn),
    .strb     (strb),
    .dmaReq   (dmaReq),
    .rstPulse (rstPulse)
  );

  ppfc_datapath #(
    .LVL_W (LVL_W),
    .TH_L0 (TH_L0),
    .TH_L1 (TH_L1),
    .TH_L2 (TH_L2),
    .TH_L3 (TH_L3)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrHigh       (wrData[7:3]),
    .ierBit1      (ierBit1),
    .fifoLevel    (fifoLevel),
    .reverseDir   (reverseDir),
    .dmaEn        (dmaEn),
    .wideAccess   (wideAccess),
    .opMode       (opMode),
    .dataAvailIrq (dataAvailIrq),
    .rdData       (rdData)
  );

  assign fifoRstPulse = rstPulse[0];
  assign devRstPulse  = rstPulse[1];

endmodule

// File: rtl/ppfc_reg_chk.sv
module ppfc_reg_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input logic             ierBit1,
  input logic             dmaAck,
  input logic             dmaTc,
  input logic             dmaReq,
  input logic             fifoRstPulse,
  input logic             devRstPulse,
  input logic             wideAccess,
  input logic [2:0]       opMode,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             reverseDir,
  input logic             dataAvailIrq
);

  logic newSet;
  assign newSet = wrEn && wrData[0] && !rdData[0] && !dmaTc;

  AST_EN_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[0]) |=> !rdData[0]); // R2
  AST_REQ_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    newSet |=> (dmaReq && rdData[0])); // R3
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaAck && !newSet) |=> !dmaReq); // R4
  AST_TC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    dmaTc |=> !rdData[0]); // R5
  AST_FIFO_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRstPulse && !(wrEn && wrData[1])) |=> !fifoRstPulse); // R6
  AST_FIFO_PULSE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoRstPulse) |-> $past(wrEn && wrData[1])); // R6
  AST_DEV_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (devRstPulse && !(wrEn && wrData[2])) |=> !devRstPulse); // R7
  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(wideAccess)); // R8
  AST_MODE_BORROWED: assert property (@(posedge clk) disable iff (!rstN)
    ierBit1 |-> (opMode == 3'd4 || opMode == 3'd5)); // R9
  AST_IRQ_FWD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !reverseDir |-> !dataAvailIrq); // R10
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == '0) |-> !dataAvailIrq); // R10
  AST_RST_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[2:1] == 2'b00); // R11

endmodule

bind ppfc_reg ppfc_reg_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/ppfc_reg_tb.sv
module ppfc_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn;
  logic [7:0]       wrData;
  logic [7:0]       rdData;
  logic             ierBit1;
  logic             dmaAck;
  logic             dmaTc;
  logic             dmaReq;
  logic             fifoRstPulse;
  logic             devRstPulse;
  logic             wideAccess;
  logic [2:0]       opMode;
  logic [LVL_W-1:0] fifoLevel;
  logic             reverseDir;
  logic             dataAvailIrq;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic mEn, mReq, mFr, mDr, mWide;
  logic [1:0] mMode, mThr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppfc_reg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ierBit1(ierBit1), .dmaAck(dmaAck), .dmaTc(dmaTc), .dmaReq(dmaReq),
    .fifoRstPulse(fifoRstPulse), .devRstPulse(devRstPulse),
    .wideAccess(wideAccess), .opMode(opMode), .fifoLevel(fifoLevel),
    .reverseDir(reverseDir), .dataAvailIrq(dataAvailIrq)
  );

  function automatic int thLevel(input logic [1:0] t);
    case (t)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [2:0] expMode(input logic hi, input logic [1:0] m);
    if (hi) return m[0] ? 3'd5 : 3'd4;
    return {1'b0, m};
  endfunction

  function automatic logic expIrq(input logic dir, input int lvl, input logic [1:0] t);
    return dir && (lvl >= thLevel(t));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, check combinational outputs, advance model, check registered outputs
  task automatic step(input logic wr, input logic [7:0] d, input logic tc, input logic ack,
                      input logic ier, input logic [LVL_W-1:0] lvl, input logic dir);
    logic setReq;
    wrEn = wr; wrData = d; dmaTc = tc; dmaAck = ack;
    ierBit1 = ier; fifoLevel = lvl; reverseDir = dir;
    #1;
    chk("R9 opMode", opMode, expMode(ier, mMode));
    chk("R10 dataAvailIrq", dataAvailIrq, expIrq(dir, int'(lvl), mThr));
    chk("R11 rdData", rdData, {mThr, mMode, mWide, 2'b00, mEn});
    setReq = wr && d[0] && !mEn && !tc;
    if (setReq)   mReq = 1'b1;
    else if (ack) mReq = 1'b0;
    if (tc)       mEn = 1'b0;
    else if (wr)  mEn = d[0];
    mFr = wr && d[1];
    mDr = wr && d[2];
    if (wr) begin mWide = d[3]; mMode = d[5:4]; mThr = d[7:6]; end
    @(negedge clk);
    chk("R2 dmaEn", rdData[0], mEn);
    chk("R4 dmaReq", dmaReq, mReq);
    chk("R6 fifoRstPulse", fifoRstPulse, mFr);
    chk("R7 devRstPulse", devRstPulse, mDr);
    chk("R8 wideAccess", wideAccess, mWide);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'h1c5e_77a1);
    rstN = 1'b0; wrEn = 0; wrData = 0; dmaTc = 0; dmaAck = 0;
    ierBit1 = 0; fifoLevel = 0; reverseDir = 0;
    {mEn, mReq, mFr, mDr, mWide, mMode, mThr} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 dmaReq", dmaReq, 1'b0);
    chk("R1 pulses", {fifoRstPulse, devRstPulse}, 2'b00);
    chk("R1 wideAccess", wideAccess, 1'b0);
    chk("R1 opMode", opMode, 3'd0);

    // R3 request on enable edge, no new one on repeat write
    step(1, 8'h01, 0, 0, 0, '0, 0);
    chk("R3 request raised", dmaReq, 1'b1);
    step(0, 8'h00, 0, 1, 0, '0, 0);
    chk("R4 ack drops request", dmaReq, 1'b0);
    step(1, 8'h01, 0, 0, 0, '0, 0);
    chk("R3 no request on repeat 1", dmaReq, 1'b0);
    step(1, 8'h00, 0, 0, 0, '0, 0);
    // R5 tc wins over simultaneous set
    step(1, 8'h01, 1, 0, 0, '0, 0);
    chk("R5 tc wins enable", rdData[0], 1'b0);
    chk("R5 tc wins request", dmaReq, 1'b0);
    step(1, 8'h01, 0, 0, 0, '0, 0);
    step(0, 8'h00, 1, 0, 0, '0, 0);
    chk("R5 tc clears enable", rdData[0], 1'b0);
    // R4 re-arm while ack: set wins
    step(1, 8'h01, 0, 1, 0, '0, 0);
    chk("R4 set beats ack", dmaReq, 1'b1);
    step(0, 8'h00, 0, 1, 0, '0, 0);

    // R6 R7 pulses then idle
    step(1, 8'h02, 0, 0, 0, '0, 0);
    idle();
    step(1, 8'h04, 0, 0, 0, '0, 0);
    idle();
    step(1, 8'h06, 0, 0, 0, '0, 0);
    step(1, 8'h06, 0, 0, 0, '0, 0);
    idle();

    // R8 R9 modes and width
    for (int h = 0; h < 2; h++)
      for (int m = 0; m < 4; m++) begin
        step(1, 8'(m << 4) | 8'h08, 0, 0, logic'(h), '0, 0);
        step(0, 8'h00, 0, 0, logic'(h), '0, 0);
      end

    // R10 threshold boundaries, both directions
    for (int t = 0; t < 4; t++) begin
      step(1, 8'(t << 6), 0, 0, 0, '0, 0);
      step(0, 8'h00, 0, 0, 0, LVL_W'(thLevel(2'(t)) - 1), 1);
      step(0, 8'h00, 0, 0, 0, LVL_W'(thLevel(2'(t))), 1);
      step(0, 8'h00, 0, 0, 0, LVL_W'(thLevel(2'(t))), 0);
      step(0, 8'h00, 0, 0, 0, LVL_W'(16), 1);
    end

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 2) == 0, 8'($urandom), ($urandom % 6) == 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0, LVL_W'($urandom % 17), ($urandom % 2) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule